// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This unit produces the memory address for each access of a signal-processing datapath and then advances its pointer without help from software. It holds four configuration values: the current pointer, the start of a buffer, the buffer size and a signed step. It also holds an update mode, which is one of plain increment, wrap-around inside the buffer, or reversed-carry stepping for reordering FFT data. Software writes these values once. From then on, each accepted access presents the current pointer and moves it.

The access width travels with each request and scales the step. A byte access uses the step as written, a halfword access doubles it, and a word access quadruples it. A step wider than the buffer, or a bit-reversed traversal over a size that is not a power of two, is flagged in the same cycle and resets the pointer to the buffer start.

Requests use a valid/ready handshake. The block adds no buffering. `addr_valid` follows `req_valid` and `req_ready` follows `addr_ready`. The address is therefore stable while the consumer holds `addr_ready` low, and the pointer moves only in a cycle where both `req_valid` and `addr_ready` are high.

Top module: `agu_core`

## Requirements
- R1: After reset, the pointer, buffer start, buffer size and step all read 0, the mode is linear, and `stride_err` is low.
- R2: `addr_valid` equals `req_valid` and `req_ready` equals `addr_ready`. `addr` always shows the current pointer. The pointer changes only on an accepted access, where both `req_valid` and `addr_ready` are high, or on a pointer write.
- R3: In linear mode (mode code 0, and also code 3), an accepted access sets pointer := pointer + scaled step, modulo 2^AW.
- R4: `req_size` 0 multiplies the step by 1, 1 multiplies it by 2, and 2 or 3 multiply it by 4.
- R5: In circular mode (mode code 1) with a non-negative scaled step, a sum that is greater than or equal to start + size is reduced by size.
- R6: In circular mode with a negative scaled step, a sum below the start has size added back.
- R7: In circular mode, if |scaled step| > size, the access raises `stride_err` in that cycle and the pointer becomes the buffer start.
- R8: In bit-reversed mode (mode code 2) with size 2^k, the offset (pointer − start) is updated by adding the scaled step over the low k bits, with the carry running from the most significant bit toward the least significant bit.
- R9: In bit-reversed mode, if the size is not a power of two, the access raises `stride_err` and the pointer becomes the buffer start.
- R10: A configuration write is visible from the next cycle. If an access and a configuration write fall in the same cycle, the access uses the old values. A pointer write in that cycle replaces the access's update.
- R11: The `cfg_sel` codes are: 0 pointer, 1 start, 2 size, 3 step, 4 mode. Writes with codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target code |
| cfg_data | input | AW | Configuration value; the step is two's complement |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Access accepted when high together with `req_valid` |
| req_size | input | 2 | Access width: byte, halfword, word |
| addr_valid | output | 1 | Address is presented |
| addr_ready | input | 1 | Consumer takes the address |
| addr | output | AW | Current pointer |
| stride_err | output | 1 | Illegal step or size on this accepted access |

## Verification
Some behaviours are checked on every cycle. These are the handshake mirroring, a steady address while no access is accepted, the linear step, the pointer staying inside the buffer in circular mode, a pointer write taking effect on the next cycle, and an error forcing the pointer to the buffer start. Other behaviours show only through whole traversals in the bench's scenarios. These are the exact wrap points for positive and negative steps, the reversed-carry sequence matching FFT reordering, and the ordering of writes that land in the same cycle as an access.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN  = 2'd0,
    MODE_CIRC = 2'd1,
    MODE_BREV = 2'd2
  } agu_mode_e;

  localparam logic [2:0] SEL_IDX  = 3'd0;
  localparam logic [2:0] SEL_BASE = 3'd1;
  localparam logic [2:0] SEL_LEN  = 3'd2;
  localparam logic [2:0] SEL_STEP = 3'd3;
  localparam logic [2:0] SEL_MODE = 3'd4;
endpackage

// File: rtl/agu_cfg.sv
`timescale 1ns/1ps
module agu_cfg import agu_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q,
  output logic [AW-1:0] step_q,
  output logic [1:0]    mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      step_q <= '0;
      mode_q <= MODE_LIN;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_BASE: base_q <= cfg_data;
        SEL_LEN:  len_q  <= cfg_data;
        SEL_STEP: step_q <= cfg_data;
        SEL_MODE: mode_q <= cfg_data[1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/agu_step.sv
`timescale 1ns/1ps
module agu_step import agu_pkg::*; #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] step,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  output logic [AW-1:0] nxt,
  output logic          err
);
  logic [AW-1:0] meff, mag, sum, lim, mask, off, radd;
  logic          neg, pow2;

  function automatic logic [AW-1:0] rev_carry_add(
    input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [AW-1:0] m);
    logic [AW-1:0] r;
    logic c;
    r = '0;
    c = 1'b0;
    for (int i = AW - 1; i >= 0; i--) begin
      if (m[i]) begin
        r[i] = a[i] ^ b[i] ^ c;
        c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
      end
    end
    return r;
  endfunction

  always_comb begin
    case (size)
      2'd0:    meff = step;
      2'd1:    meff = step << 1;
      default: meff = step << 2;
    endcase
    neg  = meff[AW-1];
    mag  = neg ? (~meff + 1'b1) : meff;
    sum  = idx + meff;
    lim  = base + len;
    mask = len - 1'b1;
    pow2 = (len != '0) && ((len & mask) == '0);
    off  = (idx - base) & mask;
    radd = rev_carry_add(off, meff & mask, mask);
  end

  always_comb begin
    err = 1'b0;
    nxt = sum;
    if (mode == MODE_CIRC) begin
      if (mag > len) begin
        err = 1'b1;
        nxt = base;
      end else if (!neg && sum >= lim) begin
        nxt = sum - len;
      end else if (neg && sum < base) begin
        nxt = sum + len;
      end
    end else if (mode == MODE_BREV) begin
      if (!pow2) begin
        err = 1'b1;
        nxt = base;
      end else begin
        nxt = base + radd;
      end
    end
  end
endmodule

// File: rtl/agu_core.sv
`timescale 1ns/1ps
module agu_core import agu_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_size,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr,
  output logic          stride_err
);
  logic [AW-1:0] idx_q, base_w, len_w, step_w, nxt_w;
  logic [1:0]    mode_w;
  logic          err_w, fire;

  agu_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .base_q(base_w), .len_q(len_w),
    .step_q(step_w), .mode_q(mode_w)
  );

  agu_step #(.AW(AW)) u_step (
    .idx(idx_q), .base(base_w), .len(len_w), .step(step_w),
    .mode(mode_w), .size(req_size), .nxt(nxt_w), .err(err_w)
  );

  assign fire       = req_valid & addr_ready;
  assign req_ready  = addr_ready;
  assign addr_valid = req_valid;
  assign addr       = idx_q;
  assign stride_err = fire & err_w;

  always_ff @(posedge clk) begin
    if (!rst_n)                          idx_q <= '0;
    else if (cfg_we && cfg_sel == SEL_IDX) idx_q <= cfg_data;
    else if (fire)                       idx_q <= nxt_w;
  end
endmodule

// File: rtl/agu_chk.sv
`timescale 1ns/1ps
module agu_chk import agu_pkg::*; #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic [AW-1:0] cfg_data,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_size,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic          stride_err,
  input logic [AW-1:0] base_w,
  input logic [AW-1:0] len_w,
  input logic [AW-1:0] step_w,
  input logic [1:0]    mode_w
);
  logic          acc;
  logic [AW-1:0] sc;
  logic          in_rng;
  assign acc    = req_valid && addr_ready;
  assign sc     = (req_size == 2'd0) ? step_w : (req_size == 2'd1) ? (step_w << 1) : (step_w << 2);
  assign in_rng = (addr >= base_w) && (addr < base_w + len_w);

  // R2
  hs_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid == req_valid) && (req_ready == addr_ready));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !cfg_we) |=> $stable(addr));
  // R3
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfg_we && mode_w != MODE_CIRC && mode_w != MODE_BREV)
      |=> addr == $past(addr) + $past(sc));
  // R5
  circ_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfg_we && mode_w == MODE_CIRC && in_rng) |=> in_rng);
  // R7
  err_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stride_err && !(cfg_we && cfg_sel == SEL_IDX)) |=> addr == $past(base_w));
  // R7
  err_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stride_err |-> acc);
  // R10
  idx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_IDX) |=> addr == $past(cfg_data));
endmodule

bind agu_core agu_chk #(.AW(AW)) u_agu_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr(addr), .stride_err(stride_err), .base_w(base_w), .len_w(len_w),
  .step_w(step_w), .mode_w(mode_w)
);

// File: tb/tb_agu_core.sv
`timescale 1ns/1ps
module tb_agu_core;
  localparam int AW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic req_valid = 1'b0, addr_ready = 1'b0;
  logic [1:0] req_size = '0;
  logic req_ready, addr_valid, stride_err;
  logic [AW-1:0] addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [AW-1:0] m_idx, m_base, m_len, m_step;
  logic [1:0] m_mode;

  always #2 clk = ~clk;

  agu_core #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr(addr), .stride_err(stride_err)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int revk(int x, int k);
    int r = 0;
    for (int i = 0; i < k; i++) if (x[i]) r |= 1 << (k - 1 - i);
    return r;
  endfunction

  // reference next pointer; bit 16 of result = error
  function automatic int ref_next(int size);
    int sh = (size == 0) ? 0 : (size == 1) ? 1 : 2;
    int meff = $signed(m_step) * (1 << sh);
    int mg = (meff < 0) ? -meff : meff;
    int L = m_len;
    if (m_mode == 2'd1) begin
      int t;
      if (mg > L) return (1 << 16) | m_base;
      t = (int'(m_idx) - int'(m_base)) + meff;
      t = ((t % L) + L) % L;
      return (m_base + t) & 16'hffff;
    end else if (m_mode == 2'd2) begin
      int k, s;
      if (L == 0 || (L & (L - 1)) != 0) return (1 << 16) | m_base;
      k = $clog2(L);
      s = (revk((m_idx - m_base) & (L - 1), k) + revk(meff & (L - 1), k)) & (L - 1);
      return (m_base + revk(s, k)) & 16'hffff;
    end
    return (m_idx + meff) & 16'hffff;
  endfunction

  task automatic apply_cfg(int sel, int data);
    case (sel)
      0: m_idx = data[15:0];
      1: m_base = data[15:0];
      2: m_len = data[15:0];
      3: m_step = data[15:0];
      4: m_mode = data[1:0];
      default: ;
    endcase
  endtask

  task automatic cfg(int sel, int data);
    cfg_we = 1; cfg_sel = sel[2:0]; cfg_data = data[15:0];
    @(posedge clk); #1;
    cfg_we = 0;
    apply_cfg(sel, data);
  endtask

  // one accepted access, optionally with a same-cycle write
  task automatic acc(string tag, int size, bit wr = 0, int sel = 0, int data = 0);
    int r;
    req_valid = 1; addr_ready = 1; req_size = size[1:0];
    cfg_we = wr; cfg_sel = sel[2:0]; cfg_data = data[15:0];
    #0.5;
    r = ref_next(size);
    check({tag, " addr"}, addr, m_idx);
    check({tag, " err"}, stride_err, r[16]);
    @(posedge clk); #1;
    req_valid = 0; addr_ready = 0; cfg_we = 0;
    m_idx = r[15:0];
    if (wr) apply_cfg(sel, data);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int bo[9] = '{0, 4, 2, 6, 1, 5, 3, 7, 0};
    void'($urandom(32'd1234));
    m_idx = 0; m_base = 0; m_len = 0; m_step = 0; m_mode = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    check("R1 addr", addr, 0);
    check("R1 err", stride_err, 0);
    check("R1 valid", addr_valid, 0);
    acc("R1 zero step", 0);
    check("R1 after", addr, 0);

    // R3 R4 linear, all sizes
    cfg(0, 100); cfg(3, 3);
    acc("R3 byte", 0); check("R4 byte", addr, 103);
    acc("R4 half", 1); check("R4 half", addr, 109);
    acc("R4 word", 2); check("R4 word", addr, 121);
    acc("R4 size3", 3); check("R4 size3", addr, 133);
    cfg(3, -5); acc("R3 neg", 2); check("R3 neg", addr, 113);

    // R5 R6 circular traversals
    cfg(1, 200); cfg(2, 10); cfg(3, 3); cfg(4, 1); cfg(0, 200);
    for (int i = 0; i < 25; i++) acc("R5 circ+", 0);
    cfg(3, -3);
    for (int i = 0; i < 25; i++) acc("R6 circ-", 0);
    cfg(3, 10); acc("R7 eq-len no err", 0);
    // R7 too wide
    cfg(3, 3); cfg(0, 205);
    acc("R7 wide", 2); check("R7 clamp", addr, 200);

    // R8 bit-reversed order
    cfg(1, 64); cfg(2, 8); cfg(3, 4); cfg(4, 2); cfg(0, 64);
    for (int i = 0; i < 8; i++) begin
      acc("R8 brev", 0);
      check("R8 order", addr - 64, bo[i + 1]);
    end
    cfg(2, 12); cfg(0, 70);
    acc("R9 non-pow2", 0); check("R9 clamp", addr, 64);

    // R2 back-pressure and idle
    cfg(4, 0); cfg(3, 1); cfg(0, 500);
    req_valid = 1; addr_ready = 0;
    for (int i = 0; i < 3; i++) begin
      #0.5;
      check("R2 valid", addr_valid, 1);
      check("R2 ready", req_ready, 0);
      @(posedge clk); #1;
      check("R2 hold", addr, 500);
    end
    req_valid = 0; addr_ready = 1;
    @(posedge clk); #1; check("R2 idle", addr, 500);
    addr_ready = 0;

    // R10 same-cycle writes
    acc("R10 idx wr", 0, 1, 0, 777); check("R10 idx wins", addr, 777);
    acc("R10 step wr", 0, 1, 3, 9); check("R10 old step", addr, 778);
    acc("R10 new step", 0); check("R10 new step", addr, 787);
    // R11 unused codes
    cfg(5, 1234); cfg(6, 1); cfg(7, 2);
    acc("R11 ignored", 0); check("R11 ignored", addr, 796);

    // random traversals, all modes
    for (int s = 0; s < 40; s++) begin
      int md = $urandom_range(0, 2);
      int L, b, sz, st;
      sz = $urandom_range(0, 2);
      if (md == 2) L = 1 << $urandom_range(1, 6);
      else L = $urandom_range(1, 40);
      b = $urandom_range(64, 4000);
      if (md == 2) st = $urandom_range(0, L - 1);
      else begin
        int lim = L >> (sz == 0 ? 0 : sz);
        st = $urandom_range(0, 2 * lim) - lim;
      end
      cfg(1, b); cfg(2, L); cfg(3, st); cfg(4, md); cfg(0, b);
      for (int i = 0; i < 2 * L; i++)
        acc(md == 0 ? "R3 rand" : md == 1 ? "R5 rand" : "R8 rand", sz);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule